// File: doc/BRIEF.md
# Rotating Register File for Software-Pipelined Loops

This block is a multi-ported register file whose upper region renames itself on every loop-closing branch. A small base register is added to each logical specifier that falls in the rotating region. The sum wraps inside that region to give the physical entry. Specifiers in the lower, static region address their entries directly and ignore the base.

Each time the loop branch pulses the rotate strobe, the base steps down by one. A value written as logical register k in one iteration is therefore read as logical register k+1 in the next. A compiler can place a producer and its consumer a fixed number of specifiers apart, so that the distance encodes the latency in iterations. For example, a load result consumed three iterations later is written three specifiers below the consumer's operand.

The block has two combinational read ports and one write port. A base-clear input resets the mapping before a new loop starts.

Top module: `rot_regfile`

## Requirements
- R1: Logical registers 0 to 7 map directly to physical registers 0 to 7, whatever the base value. A static register keeps its value across any number of rotations.
- R2: Logical register L in 8..31 maps to physical 8 + ((L − 8 + base) mod 24). After one rotation, a value written as logical L (8 ≤ L ≤ 30) is read as logical L+1.
- R3: The rotating mapping wraps. After one rotation, a value written as logical 31 is read as logical 8.
- R4: The base resets to 0 on the asynchronous active-low reset. It steps down by one on each rotate pulse, goes from 0 to 23, and returns to the same mapping after 24 rotations.
- R5: A base-clear pulse sets the base to 0, which restores the mapping that held just after reset.
- R6: When base-clear and rotate are both high in one cycle, base-clear wins and the base becomes 0.
- R7: A read of the entry being written in the same cycle returns the old contents. The new value is visible from the next cycle.
- R8: A write in the same cycle as a rotate pulse is mapped with the base from before the rotation.
- R9: The two read ports are independent and may read any two specifiers at once.
- R10: With the write enable low, no entry changes, whatever the write address and data.
- R11: A value written as logical L is read as logical L+n after n rotations, for L+n ≤ 31.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the base |
| base_clr | input | 1 | Synchronous clear of the base to 0 |
| rotate | input | 1 | Loop-closing branch: base steps down by one |
| wr_en | input | 1 | Write enable |
| wr_addr | input | 5 | Logical write specifier |
| wr_data | input | 32 | Write data |
| rd0_addr | input | 5 | Logical specifier, read port 0 |
| rd0_data | output | 32 | Read data, port 0 (combinational) |
| rd1_addr | input | 5 | Logical specifier, read port 1 |
| rd1_data | output | 32 | Read data, port 1 (combinational) |

## Verification
The bench attacks the wrap at both ends.
- Logical 31 must reach logical 8 after a rotation. A design that wraps modulo 32 instead of 24 would send it into a static register.
- The base must go from 0 to 23. A plain 5-bit decrement would produce 31, and the value would only come back into place after 32 rotations instead of 24.

It also sets the same-cycle collisions against each other:
- Write during rotate must use the old base. A design using the new base would place the value one specifier off.
- Clear during rotate must leave the base at 0.
- A read during a write must show the old data. A write-through design would return the new data early.

The static registers are watched across many rotations. An offset applied to them would make their contents seem to move.

// File: rtl/rot_regfile.sv
module rot_regfile #(
  parameter int DW      = 32,
  parameter int NREG    = 32,
  parameter int NSTATIC = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    base_clr,
  input  logic                    rotate,
  input  logic                    wr_en,
  input  logic [$clog2(NREG)-1:0] wr_addr,
  input  logic [DW-1:0]           wr_data,
  input  logic [$clog2(NREG)-1:0] rd0_addr,
  output logic [DW-1:0]           rd0_data,
  input  logic [$clog2(NREG)-1:0] rd1_addr,
  output logic [DW-1:0]           rd1_data
);
  localparam int AW   = $clog2(NREG);
  localparam int NROT = NREG - NSTATIC;
  localparam int BW   = $clog2(NROT);

  logic [BW-1:0] base_q;
  logic [DW-1:0] rf [NREG];
  logic [AW-1:0] wr_phys, rd0_phys, rd1_phys;

  function automatic logic [AW-1:0] remap(input logic [AW-1:0] l, input logic [BW-1:0] b);
    int s;
    if (int'(l) < NSTATIC) return l;
    s = int'(l) - NSTATIC + int'(b);
    if (s >= NROT) s = s - NROT;
    return AW'(s + NSTATIC);
  endfunction

  assign wr_phys  = remap(wr_addr, base_q);
  assign rd0_phys = remap(rd0_addr, base_q);
  assign rd1_phys = remap(rd1_addr, base_q);

  assign rd0_data = rf[rd0_phys];
  assign rd1_data = rf[rd1_phys];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)         base_q <= '0;
    else if (base_clr)  base_q <= '0;
    else if (rotate)    base_q <= (base_q == '0) ? BW'(NROT - 1) : base_q - 1'b1;

  always_ff @(posedge clk)
    if (wr_en) rf[wr_phys] <= wr_data;
endmodule

module rot_regfile_chk #(
  parameter int NREG    = 32,
  parameter int NSTATIC = 8
) (
  input logic                            clk,
  input logic                            rst_n,
  input logic                            base_clr,
  input logic                            rotate,
  input logic [$clog2(NREG-NSTATIC)-1:0] base_q,
  input logic [$clog2(NREG)-1:0]         rd0_addr,
  input logic [$clog2(NREG)-1:0]         rd0_phys
);
  localparam int NROT = NREG - NSTATIC;

  // R5
  clear_to_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    base_clr |=> base_q == '0);
  // R6
  clear_beats_rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (base_clr && rotate) |=> base_q == '0);
  // R4
  base_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !base_clr && base_q == '0) |=> int'(base_q) == NROT - 1);
  // R4
  base_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rotate && !base_clr && base_q != '0) |=> int'(base_q) == int'($past(base_q)) - 1);
  // R4
  base_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!rotate && !base_clr) |=> $stable(base_q));
  // R4
  base_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(base_q) < NROT);
  // R1
  static_direct_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd0_addr) < NSTATIC |-> rd0_phys == rd0_addr);
  // R2
  rot_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rd0_addr) >= NSTATIC |-> int'(rd0_phys) >= NSTATIC);
endmodule

bind rot_regfile rot_regfile_chk #(.NREG(NREG), .NSTATIC(NSTATIC)) u_chk (
  .clk(clk), .rst_n(rst_n), .base_clr(base_clr), .rotate(rotate),
  .base_q(base_q), .rd0_addr(rd0_addr), .rd0_phys(rd0_phys)
);

// File: tb/tb_rot_regfile.sv
module tb_rot_regfile;
  localparam int CLK_P = 10;

  logic        clk = 0, rst_n = 0, base_clr = 0, rotate = 0, wr_en = 0;
  logic [4:0]  wr_addr = 0, rd0_addr = 0, rd1_addr = 0;
  logic [31:0] wr_data = 0, rd0_data, rd1_data;
  int nchk = 0, nfail = 0;

  rot_regfile dut (.*);

  always #(CLK_P/2) clk = ~clk;

  task automatic step();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic put(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1; wr_addr = a; wr_data = d; step(); wr_en = 0;
  endtask

  task automatic rot(input int n);
    for (int i = 0; i < n; i++) begin rotate = 1; step(); rotate = 0; end
  endtask

  task automatic expect0(input logic [4:0] a, input logic [31:0] e, input string req);
    rd0_addr = a; #1;
    nchk++;
    if (rd0_data !== e) begin
      nfail++;
      $display("FAIL %s: L%0d got %h expected %h", req, a, rd0_data, e);
    end
  endtask

  task automatic t_reset();
    put(8, 32'hA0A0_0008);
    base_clr = 1; step(); base_clr = 0;
    expect0(8, 32'hA0A0_0008, "R4 reset base zero");
  endtask

  task automatic t_static();
    put(3, 32'h0000_5A03);
    put(7, 32'h0000_5A07);
    rot(5);
    expect0(3, 32'h0000_5A03, "R1");
    expect0(7, 32'h0000_5A07, "R1");
  endtask

  task automatic t_shift();
    put(12, 32'h1200_0001);
    expect0(12, 32'h1200_0001, "R2 same iteration");
    rot(1);
    expect0(13, 32'h1200_0001, "R2 next iteration");
    put(8, 32'h0800_0003);
    rot(3);
    expect0(11, 32'h0800_0003, "R11 three rotations");
  endtask

  task automatic t_wrap();
    put(31, 32'h3100_00FF);
    rot(1);
    expect0(8, 32'h3100_00FF, "R3");
  endtask

  task automatic t_full_cycle();
    base_clr = 1; step(); base_clr = 0;
    put(20, 32'h2020_2020);
    rot(1);
    expect0(21, 32'h2020_2020, "R4 zero to 23 step");
    rot(23);
    expect0(20, 32'h2020_2020, "R4 24 rotations");
  endtask

  task automatic t_clear();
    base_clr = 1; step(); base_clr = 0;
    put(10, 32'hC1EA_0010);
    rot(5);
    base_clr = 1; step(); base_clr = 0;
    expect0(10, 32'hC1EA_0010, "R5");
    base_clr = 1; rotate = 1; step(); base_clr = 0; rotate = 0;
    expect0(10, 32'hC1EA_0010, "R6");
  endtask

  task automatic t_collide();
    put(5, 32'h0000_00AA);
    wr_en = 1; wr_addr = 5; wr_data = 32'h0000_00BB; rd0_addr = 5;
    #1; nchk++;
    if (rd0_data !== 32'h0000_00AA) begin
      nfail++; $display("FAIL R7: got %h expected %h", rd0_data, 32'h0000_00AA);
    end
    step(); wr_en = 0;
    expect0(5, 32'h0000_00BB, "R7 after write");
  endtask

  task automatic t_wr_rot();
    wr_en = 1; wr_addr = 22; wr_data = 32'hD00D_0022; rotate = 1;
    step(); wr_en = 0; rotate = 0;
    expect0(23, 32'hD00D_0022, "R8");
  endtask

  task automatic t_two_ports();
    put(2, 32'h0000_2222);
    put(25, 32'h2525_0000);
    rd0_addr = 2; rd1_addr = 25; #1;
    nchk++;
    if (rd0_data !== 32'h0000_2222) begin
      nfail++; $display("FAIL R9 port0: got %h expected %h", rd0_data, 32'h0000_2222);
    end
    nchk++;
    if (rd1_data !== 32'h2525_0000) begin
      nfail++; $display("FAIL R9 port1: got %h expected %h", rd1_data, 32'h2525_0000);
    end
  endtask

  task automatic t_no_write();
    put(14, 32'h0000_1414);
    wr_en = 0; wr_addr = 14; wr_data = 32'hDEAD_BEEF; step();
    expect0(14, 32'h0000_1414, "R10");
  endtask

  initial begin
    #(CLK_P * 100000);
    nfail++;
    $display("FAIL watchdog: got hang expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end

  initial begin
    @(negedge clk); @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_static();
    t_shift();
    t_wrap();
    t_full_cycle();
    t_clear();
    t_collide();
    t_wr_rot();
    t_two_ports();
    t_no_write();
    $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
    $finish;
  end
endmodule